// File: doc/BRIEF.md
# I2C SCL Divider Parameter Search

This block picks the clock-divider setting for an I2C master. The input clock frequency and the wanted bus rate arrive as two 32-bit numbers, and a one-cycle start pulse begins the work. The block first forms a target division ratio and a digital-filter sample value. Three integer divisions share one serial divider to do this. It then walks a grid of 64 prescaler settings. Each setting has an outer step A and an inner shift B. It keeps the smallest resulting divider that lies strictly above the target, so the bus never runs faster than requested.

When the walk ends, the block reports three things for one cycle with a done strobe: the packed 8-bit divider code, the filter value and the divider it achieves. All three stay on the outputs until the next start. The filter value enters each candidate divider, so a faster input clock pushes every candidate up by an amount that shrinks as B grows.

Top module: `scl_div_search`

## Requirements
- R1: After reset, busy and done are low, code is 0x31, the divider output is all ones (0xFFFFF) and the filter output is 0.
- R2: The target ratio is floor(clk_hz / bus_hz), clamped to 65535 when larger. It is never wrapped to 16 bits.
- R3: The filter output equals floor(5 * floor(clk_hz / 1000) / 100000).
- R4: Grid point (i, j) with i, j in 0..7 uses A = 10 + 2i and B = 16 * 2^j. Its divider is B * (A + 2 * floor(3F / B)), where F is the filter value.
- R5: The reported divider is the smallest grid divider strictly greater than the target. A divider equal to the target is not chosen.
- R6: When several grid points give the same winning divider, the one visited first wins. The visit order is i outer, ascending, then j inner, ascending.
- R7: With k = i + 4, the code carries k[1:0] in bits 1:0, j in bits 4:2 and k[2] in bit 5. Bits 7:6 are zero.
- R8: If no grid divider exceeds the target, the code is 0x31 and the divider output is 0xFFFFF.
- R9: done is high for exactly one cycle per search. busy is low after it. Code, filter and divider outputs do not change while the block is idle.
- R10: A start pulse while busy is ignored. The running search finishes with the operands captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search |
| clk_hz | input | 32 | Input clock frequency in Hz, sampled at start |
| bus_hz | input | 32 | Requested bus rate in Hz, sampled at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle strobe: results valid |
| code | output | 8 | Packed divider-ratio code |
| filt | output | 8 | Digital-filter sample value |
| div_out | output | 20 | Divider achieved by the chosen code |

## Verification
The hardest case to reach from the ports is the tie between two grid points that give the same divider. This needs a filter value small enough that the filter term drops out. It also needs a target that sits just below a divider reachable both as A=20, B=16 and as A=10, B=32. A 30 MHz clock with a 100 kHz request lands there, so that vector checks the visit order. Two other vectors each aim at one boundary. One puts the target exactly on a candidate, to check strict comparison. The other pushes the raw ratio past 16 bits, where wrapping instead of clamping would expose a small winning divider.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TGT,
    ST_KHZ,
    ST_FLT,
    ST_SRCH,
    ST_FIN
  } srch_st_e;

  localparam logic [7:0] NO_FIT_CODE = 8'h31;

endpackage

// File: rtl/scl_serial_div.sv
module scl_serial_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         rdy,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic         run_q, run_d;
  logic         rdy_q, rdy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] den_q, den_d;
  logic [W:0]   shl;
  logic [W:0]   dif;

  always_comb begin
    run_d = run_q;
    rdy_d = 1'b0;
    cnt_d = cnt_q;
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    shl   = {rem_q, quo_q[W-1]};
    dif   = shl - {1'b0, den_q};
    if (go) begin
      run_d = 1'b1;
      cnt_d = CW'(W);
      rem_d = '0;
      quo_d = num;
      den_d = den;
    end else if (run_q) begin
      if (shl >= {1'b0, den_q}) begin
        rem_d = dif[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shl[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        rdy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else begin
      run_q <= run_d;
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
    end
  end

  assign rdy = rdy_q;
  assign quo = quo_q;
endmodule

// File: rtl/scl_grid_eval.sv
module scl_grid_eval #(
  parameter int FILT_W = 8,
  parameter int DIV_W  = 20,
  parameter int IDX_W  = 3,
  parameter int A_MIN  = 10,
  parameter int A_STEP = 2,
  parameter int SH0    = 4,
  parameter int K0     = 4
) (
  input  logic [IDX_W-1:0]  ga_off,
  input  logic [IDX_W-1:0]  gb,
  input  logic [FILT_W-1:0] filt,
  output logic [DIV_W-1:0]  cand,
  output logic [7:0]        code
);
  localparam int TRI_W = FILT_W + 2;

  logic [TRI_W-1:0] tri3;
  logic [TRI_W-1:0] qb;
  logic [DIV_W-1:0] a_val;
  logic [DIV_W-1:0] sum;
  logic [IDX_W:0]   kk;

  always_comb begin
    tri3  = {2'b00, filt} + {1'b0, filt, 1'b0};
    qb    = tri3 >> (SH0 + int'(gb));
    a_val = DIV_W'(A_MIN) + DIV_W'(ga_off) * DIV_W'(A_STEP);
    sum   = a_val + (DIV_W'(qb) << 1);
    cand  = sum << (SH0 + int'(gb));
    kk    = (IDX_W + 1)'(K0) + {1'b0, ga_off};
    code  = {2'b00, kk[2], gb, kk[1:0]};
  end
endmodule

// File: rtl/scl_div_search.sv
module scl_div_search
  import scl_div_pkg::*;
#(
  parameter int CLK_W    = 32,
  parameter int TGT_W    = 16,
  parameter int FILT_W   = 8,
  parameter int DIV_W    = 20,
  parameter int IDX_W    = 3,
  parameter int KHZ_DIV  = 1000,
  parameter int FILT_MUL = 5,
  parameter int FILT_DIV = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CLK_W-1:0]  clk_hz,
  input  logic [CLK_W-1:0]  bus_hz,
  output logic              busy,
  output logic              done,
  output logic [7:0]        code,
  output logic [FILT_W-1:0] filt,
  output logic [DIV_W-1:0]  div_out
);
  localparam int PT_W = 2 * IDX_W;

  logic [1:0]        rs_q;
  logic              rst_s_n;
  srch_st_e          st_q, st_d;
  logic [CLK_W-1:0]  clk_q, clk_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;
  logic [FILT_W-1:0] filt_q, filt_d;
  logic [DIV_W-1:0]  best_q, best_d;
  logic [7:0]        code_q, code_d;
  logic [PT_W-1:0]   pt_q, pt_d;
  logic              dv_go, dv_rdy;
  logic [CLK_W-1:0]  dv_num, dv_den, dv_quo;
  logic [DIV_W-1:0]  cand;
  logic [7:0]        cand_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  scl_serial_div #(.W(CLK_W)) u_div (
    .clk  (clk),
    .rst_n(rst_s_n),
    .go   (dv_go),
    .num  (dv_num),
    .den  (dv_den),
    .rdy  (dv_rdy),
    .quo  (dv_quo)
  );

  scl_grid_eval #(
    .FILT_W(FILT_W), .DIV_W(DIV_W), .IDX_W(IDX_W),
    .A_MIN(10), .A_STEP(2), .SH0(4), .K0(4)
  ) u_grid (
    .ga_off(pt_q[PT_W-1:IDX_W]),
    .gb    (pt_q[IDX_W-1:0]),
    .filt  (filt_q),
    .cand  (cand),
    .code  (cand_code)
  );

  always_comb begin
    st_d   = st_q;
    clk_d  = clk_q;
    tgt_d  = tgt_q;
    filt_d = filt_q;
    best_d = best_q;
    code_d = code_q;
    pt_d   = pt_q;
    dv_go  = 1'b0;
    dv_num = clk_hz;
    dv_den = bus_hz;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          dv_go = 1'b1;
          clk_d = clk_hz;
          st_d  = ST_TGT;
        end
      end
      ST_TGT: begin
        dv_num = clk_q;
        dv_den = CLK_W'(KHZ_DIV);
        if (dv_rdy) begin
          tgt_d = (|dv_quo[CLK_W-1:TGT_W]) ? '1 : dv_quo[TGT_W-1:0];
          dv_go = 1'b1;
          st_d  = ST_KHZ;
        end
      end
      ST_KHZ: begin
        dv_num = dv_quo * CLK_W'(FILT_MUL);
        dv_den = CLK_W'(FILT_DIV);
        if (dv_rdy) begin
          dv_go = 1'b1;
          st_d  = ST_FLT;
        end
      end
      ST_FLT: begin
        if (dv_rdy) begin
          filt_d = dv_quo[FILT_W-1:0];
          best_d = '1;
          code_d = NO_FIT_CODE;
          pt_d   = '0;
          st_d   = ST_SRCH;
        end
      end
      ST_SRCH: begin
        if ((cand > DIV_W'(tgt_q)) && (cand < best_q)) begin
          best_d = cand;
          code_d = cand_code;
        end
        pt_d = pt_q + PT_W'(1);
        if (&pt_q) st_d = ST_FIN;
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      clk_q  <= '0;
      tgt_q  <= '0;
      filt_q <= '0;
      best_q <= '1;
      code_q <= NO_FIT_CODE;
      pt_q   <= '0;
    end else begin
      st_q   <= st_d;
      clk_q  <= clk_d;
      tgt_q  <= tgt_d;
      filt_q <= filt_d;
      best_q <= best_d;
      code_q <= code_d;
      pt_q   <= pt_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_FIN);
  assign code    = code_q;
  assign filt    = filt_q;
  assign div_out = best_q;
endmodule

// File: rtl/scl_div_search_chk.sv
module scl_div_search_chk #(
  parameter int TGT_W  = 16,
  parameter int FILT_W = 8,
  parameter int DIV_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [7:0]        code,
  input logic [FILT_W-1:0] filt,
  input logic [DIV_W-1:0]  div_out,
  input logic [TGT_W-1:0]  tgt_q
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(code) && $stable(filt) && $stable(div_out)));

  // R5
  above_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((&div_out) || (div_out > DIV_W'(tgt_q))));

  // R8
  no_fit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&div_out)) |-> (code == 8'h31));

  // R7
  code_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (code[7:6] == 2'b00));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind scl_div_search scl_div_search_chk #(
  .TGT_W(TGT_W), .FILT_W(FILT_W), .DIV_W(DIV_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .code   (code),
  .filt   (filt),
  .div_out(div_out),
  .tgt_q  (tgt_q)
);

// File: tb/sim_scl_div_search.sv
module sim_scl_div_search;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] clk_hz;
  logic [31:0] bus_hz;
  logic        busy;
  logic        done;
  logic [7:0]  code;
  logic [7:0]  filt;
  logic [19:0] div_out;

  int total;
  int bad;

  // row: {clk_hz, bus_hz, code, filt, div}
  localparam int NV = 7;
  localparam logic [99:0] VEC [NV] = '{
    {32'd100000000,  32'd100000,  8'h2B, 8'd5,   20'd1024},
    {32'd66000000,   32'd400000,  8'h21, 8'd3,   20'd192},
    {32'd400000000,  32'd1000000, 8'h01, 8'd20,  20'd416},
    {32'd64000000,   32'd400000,  8'h21, 8'd3,   20'd192},
    {32'd30000000,   32'd100000,  8'h24, 8'd1,   20'd320},
    {32'd4000000000, 32'd1,       8'h31, 8'd200, 20'hFFFFF},
    {32'd70000000,   32'd1000,    8'h31, 8'd3,   20'hFFFFF}
  };

  scl_div_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_hz(clk_hz), .bus_hz(bus_hz),
    .busy(busy), .done(done), .code(code), .filt(filt), .div_out(div_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] c, input logic [31:0] s);
    @(negedge clk);
    clk_hz = c;
    bus_hz = s;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk({req, " timeout"}, 32'd0, 32'd1);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    start = 1'b0;
    clk_hz = '0;
    bus_hz = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 code", 32'(code), 32'h31);
    chk("R1 div", 32'(div_out), 32'hFFFFF);
    chk("R1 filt", 32'(filt), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      pulse_start(VEC[i][99:68], VEC[i][67:36]);
      wait_done("R9 table");
      chk("R7 R4 code", 32'(code), 32'(VEC[i][35:28]));
      chk("R3 filt", 32'(filt), 32'(VEC[i][27:20]));
      chk("R5 R6 R8 R2 div", 32'(div_out), 32'(VEC[i][19:0]));
      @(negedge clk);
      chk("R9 done one cycle", 32'(done), 32'd0);
      chk("R9 busy low", 32'(busy), 32'd0);
    end

    // R9 hold while idle, with changed inputs and no start
    clk_hz = 32'd66000000;
    bus_hz = 32'd400000;
    repeat (20) @(negedge clk);
    chk("R9 hold code", 32'(code), 32'h31);
    chk("R9 hold div", 32'(div_out), 32'hFFFFF);
    chk("R9 hold filt", 32'(filt), 32'd3);

    // R10 start while busy is ignored
    pulse_start(32'd100000000, 32'd100000);
    repeat (10) @(negedge clk);
    chk("R10 busy", 32'(busy), 32'd1);
    pulse_start(32'd66000000, 32'd400000);
    wait_done("R10");
    chk("R10 code", 32'(code), 32'h2B);
    chk("R10 div", 32'(div_out), 32'd1024);
    chk("R10 filt", 32'(filt), 32'd5);
    @(negedge clk);
    chk("R10 no second run", 32'(busy), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule